// File: doc/BRIEF.md
# Program/Verify Address Counter and Region Mapper

This block keeps the 14-bit word counter that a small microcontroller uses while it is held in its serial program/verify mode. It turns that counter into the addresses used by three stores: a 1K-word user program array, a 16-word configuration array, and a 64-byte data array. It also produces the gating flags that a read or write path uses when code protection is on. The serial shifter and the storage arrays are outside the block. The command decoder drives three one-cycle strobes: `rst` when the mode is left or entered, `inc` for an address-increment command, and `load_cfg` for a load-configuration command. `protect` is a level that reflects the code-protect setting.

The counter has two halves, and each wraps on its own. The lower half, 0x0000 to 0x1FFF, is user program space. The upper half, 0x2000 to 0x3FFF, is configuration space. When the counter is in the upper half, bit 13 stays set until a reset clears it.

Inside configuration space, only the sixteen words 0x2000 to 0x200F are real configuration locations. The ID words are at 0x2000 to 0x2003 and the device word is at 0x2007. Every higher configuration address falls through onto user program memory.

All outputs are registered. Each output reflects the strobes and the `protect` level sampled at the previous rising clock edge.

Top module: `pgm_addr_mapper`

## Requirements
- R1: While `rst` is high at a rising edge, the counter becomes 0x0000 after that edge. This clears bit 13 even from configuration space. After the same edge, `prog_addr`, `data_addr` and `cfg_sel` are 0. `rst` takes priority over `load_cfg` and `inc`.
- R2: When the counter is below 0x2000, `inc` adds one. From 0x1FFF the counter wraps to 0x0000.
- R3: When the counter is at or above 0x2000, `inc` adds one and bit 13 is kept at 1. From 0x3FFF the counter wraps to 0x2000. Only `rst` clears bit 13.
- R4: `load_cfg` sets the counter to 0x2000. When `inc` is high in the same cycle, `load_cfg` wins.
- R5: `prog_addr` always equals bits 9:0 of the counter. Any user address above 0x3FF therefore aliases into the 1K implemented words.
- R6: `cfg_sel` is 1 exactly when the counter lies in 0x2000 to 0x200F. In that case `prog_addr[3:0]` indexes the configuration array. At 0x2010 and above, `cfg_sel` is 0, so the access goes to user memory at `prog_addr`.
- R7: `data_addr` always equals bits 5:0 of the counter, so the data array is addressed modulo 64.
- R8: `prog_rd_zero` is 1 when `protect` is 1 and `cfg_sel` is 0; program reads are then forced to zero. `data_rd_ones` is equal to `protect`; data reads are then forced to all ones.
- R9: `prog_wr_ok` is 1 when `protect` is 0 or `cfg_sel` is 1, so ID and device words stay writable under protection. `data_wr_ok` is the inverse of `protect`.
- R10: Every output changes only at the rising edge that samples the strobe or `protect` change it responds to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also sent when the mode is left |
| inc | input | 1 | Address-increment strobe |
| load_cfg | input | 1 | Load-configuration strobe (jump to 0x2000) |
| protect | input | 1 | Code-protect level |
| cnt_o | output | 14 | Current counter value |
| prog_addr | output | 10 | Physical program/configuration word address |
| cfg_sel | output | 1 | Access targets the configuration array |
| data_addr | output | 6 | Physical data array address |
| prog_rd_zero | output | 1 | Force program read data to zero |
| data_rd_ones | output | 1 | Force data read data to all ones |
| prog_wr_ok | output | 1 | Program/configuration write allowed |
| data_wr_ok | output | 1 | Data write allowed |

## Verification
Each result is due exactly one rising edge after the strobe or `protect` level that causes it. The delay comes from one register stage: the next counter value and the decode are both computed before that edge and captured on it.

The driver changes inputs on the falling edge. At the same moment, it pushes the expected counter, addresses and gating flags onto the scoreboard queue. The monitor pops that entry 1 ns after the following rising edge, so every comparison lands on the cycle in which the result first appears.

The stimulus walks the whole of both halves, which covers the 0x3FF aliasing, the modulo-64 data address, and both wrap points. It also includes a collision of the two strobes, a reset issued from configuration space, and changes of `protect` both inside and outside the configuration window.

// File: rtl/pgm_map_pkg.sv
package pgm_map_pkg;
  // gating flags handed to the read/write paths
  typedef struct packed {
    logic prog_rd_zero;
    logic data_rd_ones;
    logic prog_wr_ok;
    logic data_wr_ok;
  } gate_t;

  localparam int unsigned CFG_BASE_BIT = 13;
endpackage

// File: rtl/pgm_cnt_core.sv
module pgm_cnt_core #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             load_cfg,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  localparam int unsigned LOW_W = CNT_W - 1;
  localparam logic [CNT_W-1:0] CFG_START = {1'b1, {LOW_W{1'b0}}};

  logic [LOW_W-1:0] low_inc;

  assign low_inc = cnt_q[LOW_W-1:0] + 1'b1;

  // reset > load_cfg > inc; the top bit is carried through every increment
  always_comb begin
    if (rst)           cnt_d = '0;
    else if (load_cfg) cnt_d = CFG_START;
    else if (inc)      cnt_d = {cnt_q[CNT_W-1], low_inc};
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pgm_region_dec.sv
module pgm_region_dec #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned USER_AW = 10,
  parameter int unsigned CFG_AW  = 4,
  parameter int unsigned DATA_AW = 6
) (
  input  logic [CNT_W-1:0]   cnt,
  output logic [USER_AW-1:0] prog_addr,
  output logic               cfg_sel,
  output logic [DATA_AW-1:0] data_addr
);
  localparam int unsigned MID_W = CNT_W - 1 - CFG_AW;

  logic [MID_W-1:0] mid_bits;

  assign mid_bits  = cnt[CNT_W-2:CFG_AW];
  assign prog_addr = cnt[USER_AW-1:0];
  assign data_addr = cnt[DATA_AW-1:0];
  // only the first 2**CFG_AW words of the upper half are real config words
  assign cfg_sel   = cnt[CNT_W-1] && (mid_bits == '0);
endmodule

// File: rtl/pgm_gate.sv
module pgm_gate
  import pgm_map_pkg::*;
(
  input  logic  cfg_sel,
  input  logic  protect,
  output gate_t gate
);
  always_comb begin
    gate.prog_rd_zero = protect && !cfg_sel;
    gate.data_rd_ones = protect;
    gate.prog_wr_ok   = !protect || cfg_sel;
    gate.data_wr_ok   = !protect;
  end
endmodule

// File: rtl/pgm_addr_mapper.sv
module pgm_addr_mapper
  import pgm_map_pkg::*;
#(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned USER_AW = 10,
  parameter int unsigned CFG_AW  = 4,
  parameter int unsigned DATA_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               load_cfg,
  input  logic               protect,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [USER_AW-1:0] prog_addr,
  output logic               cfg_sel,
  output logic [DATA_AW-1:0] data_addr,
  output logic               prog_rd_zero,
  output logic               data_rd_ones,
  output logic               prog_wr_ok,
  output logic               data_wr_ok
);
  logic [CNT_W-1:0]   cnt_d;
  logic [USER_AW-1:0] prog_addr_d;
  logic [DATA_AW-1:0] data_addr_d;
  logic               cfg_sel_d;
  gate_t              gate_d;
  gate_t              gate_q;

  pgm_cnt_core #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .inc      (inc),
    .load_cfg (load_cfg),
    .cnt_q    (cnt_o),
    .cnt_d    (cnt_d)
  );

  // decode the next count so the address outputs line up with cnt_o
  pgm_region_dec #(
    .CNT_W(CNT_W), .USER_AW(USER_AW), .CFG_AW(CFG_AW), .DATA_AW(DATA_AW)
  ) u_dec (
    .cnt       (cnt_d),
    .prog_addr (prog_addr_d),
    .cfg_sel   (cfg_sel_d),
    .data_addr (data_addr_d)
  );

  pgm_gate u_gate (
    .cfg_sel (cfg_sel_d),
    .protect (protect),
    .gate    (gate_d)
  );

  always_ff @(posedge clk) begin
    prog_addr <= prog_addr_d;
    data_addr <= data_addr_d;
    cfg_sel   <= cfg_sel_d;
    gate_q    <= gate_d;
  end

  assign prog_rd_zero = gate_q.prog_rd_zero;
  assign data_rd_ones = gate_q.data_rd_ones;
  assign prog_wr_ok   = gate_q.prog_wr_ok;
  assign data_wr_ok   = gate_q.data_wr_ok;
endmodule

// File: rtl/pgm_addr_mapper_chk.sv
module pgm_addr_mapper_chk #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned USER_AW = 10,
  parameter int unsigned CFG_AW  = 4,
  parameter int unsigned DATA_AW = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               inc,
  input logic               load_cfg,
  input logic               protect,
  input logic [CNT_W-1:0]   cnt_o,
  input logic [USER_AW-1:0] prog_addr,
  input logic               cfg_sel,
  input logic [DATA_AW-1:0] data_addr,
  input logic               prog_rd_zero,
  input logic               data_rd_ones,
  input logic               prog_wr_ok,
  input logic               data_wr_ok
);
  localparam logic [CNT_W-1:0] USER_TOP = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CFG_TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CFG_BASE = {1'b1, {(CNT_W-1){1'b0}}};

  p_reset_r1: assert property (@(posedge clk) rst |=> (cnt_o == '0 && !cfg_sel));

  p_user_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == USER_TOP && inc && !load_cfg) |=> cnt_o == '0);

  p_cfg_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CFG_TOP && inc && !load_cfg) |=> cnt_o == CFG_BASE);

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_o[CNT_W-1] |=> cnt_o[CNT_W-1]);

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    load_cfg |=> cnt_o == CFG_BASE);

  p_alias_r5: assert property (@(posedge clk) disable iff (rst)
    prog_addr == cnt_o[USER_AW-1:0]);

  p_window_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_sel |-> (cnt_o[CNT_W-1] && cnt_o[CNT_W-2:CFG_AW] == '0));

  p_data_mod_r7: assert property (@(posedge clk) disable iff (rst)
    data_addr == cnt_o[DATA_AW-1:0]);

  p_rd_gate_r8: assert property (@(posedge clk) disable iff (rst)
    protect |=> (data_rd_ones && (prog_rd_zero != cfg_sel)));

  p_wr_gate_r9: assert property (@(posedge clk) disable iff (rst)
    data_wr_ok |-> (prog_wr_ok && !data_rd_ones));
endmodule

bind pgm_addr_mapper pgm_addr_mapper_chk #(
  .CNT_W(CNT_W), .USER_AW(USER_AW), .CFG_AW(CFG_AW), .DATA_AW(DATA_AW)
) u_chk (
  .clk(clk), .rst(rst), .inc(inc), .load_cfg(load_cfg), .protect(protect),
  .cnt_o(cnt_o), .prog_addr(prog_addr), .cfg_sel(cfg_sel),
  .data_addr(data_addr), .prog_rd_zero(prog_rd_zero),
  .data_rd_ones(data_rd_ones), .prog_wr_ok(prog_wr_ok), .data_wr_ok(data_wr_ok)
);

// File: tb/pgm_addr_mapper_tb.sv
`timescale 1ns/1ps
module pgm_addr_mapper_tb;
  logic clk = 1'b0;
  logic rst = 1'b1, inc = 1'b0, load_cfg = 1'b0, protect = 1'b0;
  logic [13:0] cnt_o;
  logic [9:0]  prog_addr;
  logic        cfg_sel;
  logic [5:0]  data_addr;
  logic        prog_rd_zero, data_rd_ones, prog_wr_ok, data_wr_ok;

  always #2.5 clk = ~clk;

  pgm_addr_mapper u_dut (
    .clk(clk), .rst(rst), .inc(inc), .load_cfg(load_cfg), .protect(protect),
    .cnt_o(cnt_o), .prog_addr(prog_addr), .cfg_sel(cfg_sel),
    .data_addr(data_addr), .prog_rd_zero(prog_rd_zero),
    .data_rd_ones(data_rd_ones), .prog_wr_ok(prog_wr_ok), .data_wr_ok(data_wr_ok)
  );

  typedef struct packed {
    logic [13:0] cnt;
    logic [9:0]  pa;
    logic        cs;
    logic [5:0]  da;
    logic [3:0]  gates;  // {rd_zero, rd_ones, pwr_ok, dwr_ok}
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, fails = 0;
  logic [13:0] mcnt = '0;
  bit    done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // driver: one step, pushes expected outputs after the next rising edge
  task automatic step(input logic r, input logic i, input logic l, input logic p, input string tag);
    exp_t e;
    logic in_cfg;
    @(negedge clk);
    rst = r; inc = i; load_cfg = l; protect = p;
    if (r)      mcnt = 14'h0000;
    else if (l) mcnt = 14'h2000;
    else if (i) mcnt = {mcnt[13], mcnt[12:0] + 13'd1};
    in_cfg  = (mcnt >= 14'h2000) && (mcnt <= 14'h200F);
    e.cnt   = mcnt;
    e.pa    = mcnt[9:0];
    e.cs    = in_cfg;
    e.da    = mcnt[5:0];
    e.gates = {p && !in_cfg, p, !p || in_cfg, !p};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t,    "cnt",       32'(cnt_o),     32'(e.cnt));
      chk("R5", "prog_addr", 32'(prog_addr), 32'(e.pa));
      chk("R6", "cfg_sel",   32'(cfg_sel),   32'(e.cs));
      chk("R7", "data_addr", 32'(data_addr), 32'(e.da));
      chk("R8", "rd_gates",  32'({prog_rd_zero, data_rd_ones}), 32'(e.gates[3:2]));
      chk("R9", "wr_gates",  32'({prog_wr_ok, data_wr_ok}),     32'(e.gates[1:0]));
    end
  end

  initial begin
    step(1, 0, 0, 0, "R1");               // reset state
    step(1, 0, 0, 0, "R1");
    step(0, 0, 1, 0, "R4");               // jump to 0x2000
    for (int k = 0; k < 7; k++) step(0, 1, 0, 1, "R3");  // to 0x2007, protected
    step(0, 0, 0, 0, "R10");              // hold, protect drops
    step(1, 1, 1, 0, "R1");               // reset beats both strobes, leaves config half
    // whole user half, protect toggling every 1000 steps
    for (int k = 0; k < 8191; k++) step(0, 1, 0, ((k / 1000) % 2) == 1, "R2");
    step(0, 1, 0, 1, "R2");               // 0x1FFF -> 0x0000
    step(0, 1, 0, 0, "R2");
    step(0, 1, 1, 0, "R4");               // load beats inc -> 0x2000
    for (int k = 0; k < 20; k++) step(0, 1, 0, 1, "R6");  // crosses 0x200F -> 0x2010
    for (int k = 0; k < 8171; k++) step(0, 1, 0, ((k / 777) % 2) == 0, "R3");
    step(0, 1, 0, 1, "R3");               // 0x3FFF -> 0x2000
    step(0, 1, 0, 0, "R3");
    step(1, 0, 0, 1, "R1");               // reset releases bit 13
    step(0, 1, 0, 0, "R2");
    @(negedge clk);
    rst = 0; inc = 0; load_cfg = 0;
    @(posedge clk); #2;
    if (mcnt != 14'h0001) begin
      checks++; fails++;
      $display("FAIL R1 model actual=%0h expected=1", mcnt);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule